// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block produces the repeating input-multiplexer frame for a four-channel metering front end. It runs on the system clock and moves forward only on a one-cycle enable, `tick_i`, that marks each cycle of the slow conversion clock. A frame starts with a sync pulse. Channels 0 to N-1 are then converted in ascending order, each for a fixed number of ticks. One final tick is left idle so the reference can recover before the next frame begins. The start of every frame is also the start of a compute pass, which is signalled on a separate strobe.

The ADC and the compute engine sit outside this block. Towards the ADC, the block drives the channel select and start/done strobes. Towards the data memory, it drives a write enable and the index of the channel that has just finished. Towards the transfer logic, it raises a busy flag for one whole frame out of every PRESAMPS × SUM_CYCLES passes. All settings are captured at a frame boundary, so changing them never cuts a frame short.

Top module: `mux_frame_seq`

## Requirements
- R1: After reset every strobe is 0, `xfer_busy_o` is 0, `chan_o` is 0 and `settle_o` is 1. The first tick after reset starts a frame.
- R2: A frame converts N = `div_i`+1 channels (value 0 gives one conversion, value 3 gives four). Channels go in ascending order from 0, and `chan_o` holds the channel that is converting.
- R3: A conversion lasts 2 ticks when `flen_i`=0 and 3 ticks when `flen_i`=1. Frame start to frame start is therefore 1 + N×2 or 1 + N×3 ticks.
- R4: After the last conversion finishes, `settle_o` is 1 for exactly one tick interval. During that interval `chan_o` keeps the last channel.
- R5: `mux_sync_o` and `pass_start_o` pulse in the clock cycle after the tick that starts a frame. The same cycle carries `conv_start_o` with `chan_o`=0.
- R6: `conv_done_o` and `dmem_we_o` pulse in the clock cycle after the tick that ends a conversion. `dmem_idx_o` gives the channel that ended. If another conversion follows, its `conv_start_o` is in the same cycle.
- R7: `div_i` and `flen_i` are sampled only on the tick that starts a frame. Changing them in the middle of a frame does not alter that frame.
- R8: With T = max(`presamps_i`,1) × max(`sumcyc_i`,1), sampled at each frame start, `xfer_busy_o` is 1 through frame k (counted from 1 after reset) exactly when k is a multiple of T. It changes only at a frame start.
- R9: In a clock cycle that follows a cycle with `tick_i` low, no strobe is asserted and `chan_o` and `settle_o` do not change.
- R10: Each strobe (`mux_sync_o`, `pass_start_o`, `conv_start_o`, `conv_done_o`, `dmem_we_o`) is one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle enable, one per conversion-clock cycle |
| div_i | input | 2 | Conversions per frame minus one |
| flen_i | input | 1 | Conversion length select: 0 = 2 ticks, 1 = 3 ticks |
| presamps_i | input | 6 | Pre-sample count for the transfer interval (0 acts as 1) |
| sumcyc_i | input | 8 | Sum-cycle count for the transfer interval (0 acts as 1) |
| mux_sync_o | output | 1 | Frame sync pulse |
| chan_o | output | 2 | Channel being converted |
| settle_o | output | 1 | Reference settle slot active |
| conv_start_o | output | 1 | Conversion start strobe |
| conv_done_o | output | 1 | Conversion complete strobe |
| dmem_we_o | output | 1 | Data-memory write enable for the finished result |
| dmem_idx_o | output | 2 | Channel index of the finished result |
| pass_start_o | output | 1 | Compute-pass start pulse |
| xfer_busy_o | output | 1 | Transfer-busy flag, held for one frame |

## Verification
The hardest case to reach is a settings change in the middle of a frame. The inputs have to change after the frame has latched them, and the bench then has to show that the current frame still follows the old length while the next one follows the new. The bench starts a frame with four long conversions and then switches to one short conversion on the following tick. It checks every tick of the remaining old frame against a model built from the old settings, and then checks the next frame against the new settings. The transfer interval is covered in the same way. Each table row resets the block and runs enough frames to pass at least one interval boundary, including rows where the count inputs are zero.

// File: rtl/mux_frame_pkg.sv
// Shared definitions for the multiplexer frame sequencer.
// Assumes conversion lengths of two or three ticks, stored as length-1.
package mux_frame_pkg;

    typedef enum logic {
        PH_CONV   = 1'b0,
        PH_SETTLE = 1'b1
    } phase_t;

    localparam int LEN_W = 2;
    localparam logic [LEN_W-1:0] SHORT_LEN_M1 = 2'd1;
    localparam logic [LEN_W-1:0] LONG_LEN_M1  = 2'd2;

    // Map the length select to a tick count minus one.
    function automatic logic [LEN_W-1:0] len_m1(input logic long_sel);
        return long_sel ? LONG_LEN_M1 : SHORT_LEN_M1;
    endfunction

endpackage

// File: rtl/mux_frame_timer.sv
// Frame timer: walks the conversion slots and the settle slot, one step per tick.
// Assumes tick_i is high for a single clock cycle per conversion-clock cycle.
// Settings are latched only on the tick that starts a frame.
module mux_frame_timer
    import mux_frame_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [CH_W-1:0] div_i,
    input  logic            flen_i,
    output logic            frame_begin_o,
    output logic            frame_start_o,
    output logic [CH_W-1:0] chan_o,
    output logic            settle_o,
    output logic            conv_start_o,
    output logic            conv_done_o,
    output logic [CH_W-1:0] done_idx_o
);

    phase_t            phase_q;
    logic [CH_W-1:0]   idx_q;
    logic [CH_W-1:0]   last_q;
    logic [LEN_W-1:0]  sub_q;
    logic [LEN_W-1:0]  lenm1_q;
    logic              frame_start_q;
    logic              start_q;
    logic              done_q;
    logic [CH_W-1:0]   done_idx_q;

    logic frame_begin;
    logic conv_end;
    logic last_conv;

    // Decode the events of the current tick.
    always_comb begin
        frame_begin = tick_i && (phase_q == PH_SETTLE);
        conv_end    = tick_i && (phase_q == PH_CONV) && (sub_q == lenm1_q);
        last_conv   = (idx_q == last_q);
    end

    // Advance phase, channel and sub-tick counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_SETTLE;
            idx_q   <= '0;
            sub_q   <= '0;
            last_q  <= '0;
            lenm1_q <= SHORT_LEN_M1;
        end else if (frame_begin) begin
            phase_q <= PH_CONV;
            idx_q   <= '0;
            sub_q   <= '0;
            last_q  <= div_i;
            lenm1_q <= len_m1(flen_i);
        end else if (conv_end) begin
            sub_q <= '0;
            if (last_conv) begin
                phase_q <= PH_SETTLE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (tick_i && (phase_q == PH_CONV)) begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // Register the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start_q <= 1'b0;
            start_q       <= 1'b0;
            done_q        <= 1'b0;
            done_idx_q    <= '0;
        end else begin
            frame_start_q <= frame_begin;
            start_q       <= frame_begin || (conv_end && !last_conv);
            done_q        <= conv_end;
            if (conv_end) begin
                done_idx_q <= idx_q;
            end
        end
    end

    assign frame_begin_o = frame_begin;
    assign frame_start_o = frame_start_q;
    assign chan_o        = idx_q;
    assign settle_o      = (phase_q == PH_SETTLE);
    assign conv_start_o  = start_q;
    assign conv_done_o   = done_q;
    assign done_idx_o    = done_idx_q;

    AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONV) |-> (sub_q <= lenm1_q)); // R3
    AST_SETTLE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_o && tick_i) |=> !settle_o); // R4
    AST_CHAN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !settle_o |-> (chan_o <= last_q)); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_begin |=> ($stable(last_q) && $stable(lenm1_q))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (!conv_start_o && !conv_done_o && $stable(chan_o) && $stable(settle_o))); // R9
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_o |=> !conv_done_o); // R10

endmodule

// File: rtl/mux_pass_counter.sv
// Pass counter: counts compute passes and flags every interval-th pass.
// Assumes frame_begin_i is a one-cycle pulse on the tick that starts a frame.
// A count input of zero is treated as one; the interval is resampled every pass.
module mux_pass_counter #(
    parameter int PRE_W = 6,
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_begin_i,
    input  logic [PRE_W-1:0] presamps_i,
    input  logic [SUM_W-1:0] sumcyc_i,
    output logic             xfer_busy_o
);

    localparam int TOT_W = PRE_W + SUM_W;

    logic [TOT_W-1:0] pre_eff;
    logic [TOT_W-1:0] sum_eff;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] pc_q;
    logic             busy_q;
    logic             wrap;

    // Form the interval length in passes.
    always_comb begin
        pre_eff = (presamps_i == '0) ? TOT_W'(1) : TOT_W'(presamps_i);
        sum_eff = (sumcyc_i == '0) ? TOT_W'(1) : TOT_W'(sumcyc_i);
        total   = pre_eff * sum_eff;
        wrap    = (pc_q >= (total - TOT_W'(1)));
    end

    // Count passes and hold the busy flag for the interval's last pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            busy_q <= 1'b0;
        end else if (frame_begin_i) begin
            if (wrap) begin
                pc_q   <= '0;
                busy_q <= 1'b1;
            end else begin
                pc_q   <= pc_q + TOT_W'(1);
                busy_q <= 1'b0;
            end
        end
    end

    assign xfer_busy_o = busy_q;

    AST_XFER_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_begin_i |=> $stable(xfer_busy_o)); // R8
    AST_XFER_EVERY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_begin_i && (total == TOT_W'(1))) |=> xfer_busy_o); // R8

endmodule

// File: rtl/mux_frame_seq.sv
// Top of the multiplexer frame sequencer: frame timer plus pass counter.
// Assumes tick_i is a single-cycle enable; all outputs are registered.
module mux_frame_seq #(
    parameter int CH_W  = 2,
    parameter int PRE_W = 6,
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CH_W-1:0]  div_i,
    input  logic             flen_i,
    input  logic [PRE_W-1:0] presamps_i,
    input  logic [SUM_W-1:0] sumcyc_i,
    output logic             mux_sync_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             settle_o,
    output logic             conv_start_o,
    output logic             conv_done_o,
    output logic             dmem_we_o,
    output logic [CH_W-1:0]  dmem_idx_o,
    output logic             pass_start_o,
    output logic             xfer_busy_o
);

    logic frame_begin;
    logic frame_start;
    logic done;

    mux_frame_timer #(.CH_W(CH_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .div_i         (div_i),
        .flen_i        (flen_i),
        .frame_begin_o (frame_begin),
        .frame_start_o (frame_start),
        .chan_o        (chan_o),
        .settle_o      (settle_o),
        .conv_start_o  (conv_start_o),
        .conv_done_o   (done),
        .done_idx_o    (dmem_idx_o)
    );

    mux_pass_counter #(.PRE_W(PRE_W), .SUM_W(SUM_W)) u_pass (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_begin_i (frame_begin),
        .presamps_i    (presamps_i),
        .sumcyc_i      (sumcyc_i),
        .xfer_busy_o   (xfer_busy_o)
    );

    assign mux_sync_o   = frame_start;
    assign pass_start_o = frame_start;
    assign conv_done_o  = done;
    assign dmem_we_o    = done;

    AST_SYNC_WITH_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sync_o |-> (conv_start_o && (chan_o == '0) && !settle_o)); // R5
    AST_DONE_IDX_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we_o && !settle_o) |-> (dmem_idx_o + 1'b1 == chan_o)); // R6
    AST_DONE_IDX_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we_o && settle_o) |-> (dmem_idx_o == chan_o)); // R6
    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sync_o |=> !mux_sync_o); // R10

endmodule

// File: tb/mux_frame_seq_tb.sv
module mux_frame_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] div = '0;
    logic       flen = 1'b0;
    logic [5:0] pre = '0;
    logic [7:0] sumc = '0;
    logic       sync, settle, cstart, cdone, we, pstart, xbusy;
    logic [1:0] chan, didx;

    int n_chk = 0;
    int n_fail = 0;
    int tick_no = 0;
    int last_sync = -1;
    int prev_per = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mux_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .div_i(div), .flen_i(flen),
        .presamps_i(pre), .sumcyc_i(sumc), .mux_sync_o(sync), .chan_o(chan),
        .settle_o(settle), .conv_start_o(cstart), .conv_done_o(cdone),
        .dmem_we_o(we), .dmem_idx_o(didx), .pass_start_o(pstart),
        .xfer_busy_o(xbusy)
    );

    // Stimulus table: div, flen, presamps, sumcyc, frames, expected period in ticks
    localparam int NV = 6;
    localparam int V_DIV[NV] = '{0, 1, 3, 3, 2, 0};
    localparam int V_FL [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int V_PRE[NV] = '{1, 2, 0, 1, 3, 0};
    localparam int V_SUM[NV] = '{1, 2, 3, 2, 1, 0};
    localparam int V_FRM[NV] = '{3, 5, 4, 3, 4, 2};
    localparam int V_PER[NV] = '{3, 7, 9, 13, 7, 4};

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_no = 0;
        last_sync = -1;
    endtask

    // One tick: raise for one cycle, then sample just after the updating edge
    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        tick_no++;
    endtask

    // Run one frame of n conversions of l ticks and check every tick
    task automatic run_frame(int n, int l, int frame_k, int total, int per, bit chg);
        for (int t = 0; t <= n * l; t++) begin
            int e_sync, e_cs, e_cd, e_idx, e_chan, e_set, e_xb, act, exp;
            string tag;
            do_tick();
            e_sync = (t == 0) ? 1 : 0;
            e_cd   = (t > 0 && (t % l) == 0) ? 1 : 0;
            e_idx  = e_cd ? (t / l) - 1 : 0;
            e_set  = (t == n * l) ? 1 : 0;
            e_cs   = (t == 0 || (e_cd == 1 && e_set == 0)) ? 1 : 0;
            e_chan = e_set ? n - 1 : t / l;
            e_xb   = ((frame_k % total) == 0) ? 1 : 0;
            tag = (t == 0) ? "R5 frame start" : (e_set ? "R4 settle slot" :
                  (e_cd ? "R6 conversion done" : "R2 channel order"));
            if (chg) tag = {"R7 mid-frame change / ", tag};
            act = {sync, pstart, cstart, cdone, we, settle, chan};
            exp = {e_sync[0], e_sync[0], e_cs[0], e_cd[0], e_cd[0], e_set[0], e_chan[1:0]};
            chk(tag, act, exp);
            if (e_cd == 1) chk("R6 result index", int'(didx), e_idx);
            if (t == 0) begin
                chk("R8 transfer flag", int'(xbusy), e_xb);
                if (last_sync >= 0) chk("R3 frame period", tick_no - last_sync, prev_per);
                last_sync = tick_no;
                prev_per = per;
            end
            if (chg && t == 0) begin
                div = 2'd0;
                flen = 1'b0;
            end
            // Next cycle has no tick: strobes gone, state held
            @(negedge clk);
            act = {sync, pstart, cstart, cdone, we, settle, chan};
            exp = {5'b0, e_set[0], e_chan[1:0]};
            chk("R9 R10 idle cycle", act, exp);
        end
    endtask

    initial begin
        do_reset();
        // Reset state
        chk("R1 reset outputs", int'({sync, pstart, cstart, cdone, we, xbusy, settle, chan, didx}),
            int'(11'b000000_1_00_00));

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int n, l, tot;
            div = V_DIV[v][1:0];
            flen = V_FL[v][0];
            pre = V_PRE[v][5:0];
            sumc = V_SUM[v][7:0];
            do_reset();
            chk("R1 idle before first tick", int'({settle, xbusy, sync}), 3'b100);
            n = V_DIV[v] + 1;
            l = (V_FL[v] != 0) ? 3 : 2;
            tot = ((V_PRE[v] == 0) ? 1 : V_PRE[v]) * ((V_SUM[v] == 0) ? 1 : V_SUM[v]);
            for (int f = 1; f <= V_FRM[v]; f++) begin
                run_frame(n, l, f, tot, V_PER[v], 1'b0);
            end
            do_tick();
            chk("R3 period of last table frame", tick_no - last_sync, V_PER[v]);
        end

        // Directed: settings change in the middle of a frame
        div = 2'd3;
        flen = 1'b1;
        pre = 6'd1;
        sumc = 8'd2;
        do_reset();
        run_frame(4, 3, 1, 2, 13, 1'b1);
        run_frame(1, 2, 2, 2, 3, 1'b0);
        run_frame(1, 2, 3, 2, 3, 1'b0);

        // Directed: long gap with no ticks leaves state unchanged
        repeat (20) @(negedge clk);
        chk("R9 long gap without ticks", int'({sync, cstart, cdone, settle, chan}), 6'b000_1_00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule